// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a system clock into the bit-time frame that a CAN controller uses to sample the bus and to step from bit to bit. An 8-bit divider setting stretches the input clock into a time quantum. An 8-bit timing byte sets how many quanta the propagation segment and the two phase segments last. Each bit is one synchronization quantum, then the propagation segment, then phase segment 1, then phase segment 2. One field sets the length of both phase segments.

The block watches the receive line for a recessive-to-dominant transition. Outside a frame, such a transition restarts the bit from its first quantum (hard synchronization). Inside a frame, it moves the sample point or the bit end by the measured phase error. The move is limited by a jump width, which is the phase segment length capped at four quanta. The controller around the block uses the quantum tick, the sample strobe, the bit-end strobe and the segment code to run its bit-level logic.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is held and on the first cycle after its release, `seg` reads 0 (synchronization), and neither `sample_pulse` nor `bit_end` is high.
- R2: `tq_tick` is high for one clock in every `div_sel`+1 clocks, so with `div_sel` = 0 it is high on every clock. A hard synchronization restarts this count: the first tick after it falls on the (`div_sel`+1)-th clock.
- R3: Segment codes are 0 synchronization, 1 propagation, 2 phase 1 and 3 phase 2. Within a bit they appear in that order. The synchronization segment always lasts exactly one quantum.
- R4: Timing byte bits 7..5 give the propagation length P = value+1 quanta. Bits 4..2 give the phase length S = value+1 quanta for both phase segments. Bits 1..0 are unused. An undisturbed bit lasts 1+P+2S quanta: byte 0x84 gives 10 quanta and byte 0x5C gives 20.
- R5: `sample_pulse` is high on the tick that ends phase 1, and `bit_end` is high on the tick that ends phase 2. Each is high once per bit, and they are never high together.
- R6: With `in_frame` low, a cycle in which `rx` is 0 and was 1 on the previous clock starts a new bit. From the next cycle, `seg` is 0 and all quanta of the new bit count from that point.
- R7: With `in_frame` high, such a transition during propagation or phase 1 lengthens phase 1 by min(E, J) quanta. E is the number of quanta from the end of synchronization through the quantum holding the transition. J is the jump width.
- R8: With `in_frame` high, such a transition in phase 2 shortens phase 2 by min(R, J) quanta. R is the number of phase-2 quanta left after the current one, so the bit never ends before the quantum holding the transition.
- R9: The jump width J is min(S, 4) quanta.
- R10: Only the first transition in a bit adjusts it. A transition during the synchronization segment adjusts nothing.
- R11: When a transition falls on the tick that would end phase 1, the lengthening applies first. That tick raises no `sample_pulse`, and sampling moves to the end of the lengthened phase 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 8 | Quantum divider: quantum = div_sel+1 clocks |
| timing | input | 8 | Segment lengths: [7:5] propagation, [4:2] phase, [1:0] unused |
| rx | input | 1 | Received bus level, 1 recessive, 0 dominant |
| in_frame | input | 1 | High while a frame is in progress (resync), low when idle (hard sync) |
| tq_tick | output | 1 | One-clock strobe per time quantum |
| sample_pulse | output | 1 | Strobe at the sample point (end of phase 1) |
| bit_end | output | 1 | Strobe on the last clock of the bit |
| seg | output | 2 | Current segment: 0 sync, 1 propagation, 2 phase 1, 3 phase 2 |

## Verification
The delicate coincidence is a bus transition arriving on the very tick that would close phase 1. In that same cycle the block must both compute the phase error and decide whether to sample. The bench drives a falling `rx` on the last phase-1 quantum with a divider of 0. It then confirms that no sample strobe appears on that cycle and that sampling and the bit end both shift by the jump width. A second coincidence, a transition on the final phase-2 quantum, is provoked in the same way. There the bit must end on schedule, with no shortening.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_t;

    function automatic seg_t seg_next(input seg_t s);
        case (s)
            SEG_SYNC: seg_next = SEG_PROP;
            SEG_PROP: seg_next = SEG_PH1;
            SEG_PH1:  seg_next = SEG_PH2;
            default:  seg_next = SEG_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/can_bt_prescale.sv
module can_bt_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = (pre_q.cnt >= div);
        if (tick || restart) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    output logic fall
);

    typedef struct packed {
        logic prev;
    } edg_t;

    edg_t edg_d, edg_q;

    always_comb begin
        edg_d.prev = rx;
        fall       = edg_q.prev && !rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edg_q <= '{prev: 1'b1};
        end else begin
            edg_q <= edg_d;
        end
    end

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter  int FIELD_W = 3,
    parameter  int SJW_MAX = 4,
    localparam int TW      = 2 * FIELD_W + 2,
    localparam int CNT_W   = FIELD_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timing,
    input  logic          tick,
    input  logic          fall,
    input  logic          in_frame,
    output logic          hsync,
    output logic          sample_pulse,
    output logic          bit_end,
    output seg_t          seg
);

    typedef struct packed {
        seg_t             seg;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ext;
        logic [CNT_W-1:0] cut;
        logic             done;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0] prop_len, ph_len, jw, err, step;
    logic [CNT_W-1:0] ext_n, cut_n, ph1_len, ph2_len;
    logic             resync, last, adv;

    always_comb begin
        prop_len = CNT_W'(timing[TW-1 -: FIELD_W]) + CNT_W'(1);
        ph_len   = CNT_W'(timing[FIELD_W+1 -: FIELD_W]) + CNT_W'(1);
        jw       = (ph_len > CNT_W'(SJW_MAX)) ? CNT_W'(SJW_MAX) : ph_len;

        hsync  = fall && !in_frame;
        resync = fall && in_frame && !st_q.done && (st_q.seg != SEG_SYNC);

        case (st_q.seg)
            SEG_PROP: err = st_q.cnt + CNT_W'(1);
            SEG_PH1:  err = prop_len + st_q.cnt + CNT_W'(1);
            SEG_PH2:  err = ((st_q.cnt + st_q.cut + CNT_W'(1)) < ph_len)
                            ? (ph_len - st_q.cut - st_q.cnt - CNT_W'(1)) : '0;
            default:  err = '0;
        endcase
        step = (err > jw) ? jw : err;

        ext_n = st_q.ext;
        cut_n = st_q.cut;
        if (resync && (st_q.seg == SEG_PH2)) begin
            cut_n = step;
        end else if (resync) begin
            ext_n = step;
        end
        ph1_len = ph_len + ext_n;
        ph2_len = ph_len - cut_n;

        case (st_q.seg)
            SEG_PROP: last = (st_q.cnt >= prop_len - CNT_W'(1));
            SEG_PH1:  last = (st_q.cnt >= ph1_len - CNT_W'(1));
            SEG_PH2:  last = (st_q.cnt >= ph2_len - CNT_W'(1));
            default:  last = 1'b1;
        endcase

        adv          = tick && !hsync;
        sample_pulse = adv && last && (st_q.seg == SEG_PH1);
        bit_end      = adv && last && (st_q.seg == SEG_PH2);
        seg          = st_q.seg;

        st_d      = st_q;
        st_d.ext  = ext_n;
        st_d.cut  = cut_n;
        st_d.done = st_q.done || resync;
        if (hsync) begin
            st_d = '{seg: SEG_SYNC, default: '0};
        end else if (adv) begin
            if (last) begin
                st_d.cnt = '0;
                st_d.seg = seg_next(st_q.seg);
                if (st_q.seg == SEG_PH2) begin
                    st_d.ext  = '0;
                    st_d.cut  = '0;
                    st_d.done = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seg: SEG_SYNC, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter  int DIV_W   = 8,
    parameter  int FIELD_W = 3,
    parameter  int SJW_MAX = 4,
    localparam int TW      = 2 * FIELD_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [TW-1:0]    timing,
    input  logic             rx,
    input  logic             in_frame,
    output logic             tq_tick,
    output logic             sample_pulse,
    output logic             bit_end,
    output logic [1:0]       seg
);

    import can_bt_pkg::*;

    logic fall_w, hsync_w;
    seg_t seg_w;

    can_bt_edge i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .rx   (rx),
        .fall (fall_w)
    );

    can_bt_prescale #(.DIV_W(DIV_W)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .div    (div_sel),
        .restart(hsync_w),
        .tick   (tq_tick)
    );

    can_bt_seq #(.FIELD_W(FIELD_W), .SJW_MAX(SJW_MAX)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .timing      (timing),
        .tick        (tq_tick),
        .fall        (fall_w),
        .in_frame    (in_frame),
        .hsync       (hsync_w),
        .sample_pulse(sample_pulse),
        .bit_end     (bit_end),
        .seg         (seg_w)
    );

    assign seg = seg_w;

endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_sel,
    input logic             rx,
    input logic             in_frame,
    input logic             tq_tick,
    input logic             sample_pulse,
    input logic             bit_end,
    input logic [1:0]       seg
);

    // R2: a zero divider makes every clock a quantum
    a_r2_div0_every: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == '0) |-> tq_tick);

    // R3: synchronization lasts one quantum when no hard sync can occur
    a_r3_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == 2'd0 && tq_tick && in_frame) |=> (seg == 2'd1));

    // R3: segments only step forward or restart at synchronization
    a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
        (seg != $past(seg)) |-> ((seg == 2'($past(seg) + 2'd1)) || (seg == 2'd0)));

    // R5: sampling closes phase 1
    a_r5_sample_then_ph2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pulse |=> (seg == 2'd3));

    // R5: bit end leads into synchronization
    a_r5_end_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> (seg == 2'd0));

    // R5: the two strobes never coincide
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_pulse && bit_end));

    // R6: idle falling edge restarts the bit
    a_r6_hard_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && !rx && $past(rx)) |=> (seg == 2'd0));

endmodule

bind can_bit_timer can_bt_checker #(.DIV_W(DIV_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_sel     (div_sel),
    .rx          (rx),
    .in_frame    (in_frame),
    .tq_tick     (tq_tick),
    .sample_pulse(sample_pulse),
    .bit_end     (bit_end),
    .seg         (seg)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] div_sel;
    logic [7:0] timing;
    logic       rx;
    logic       in_frame;
    logic       tq_tick, sample_pulse, bit_end;
    logic [1:0] seg;

    int n_checks = 0;
    int n_errs   = 0;

    always #5 clk = ~clk;

    can_bit_timer i_can_bit_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_sel     (div_sel),
        .timing      (timing),
        .rx          (rx),
        .in_frame    (in_frame),
        .tq_tick     (tq_tick),
        .sample_pulse(sample_pulse),
        .bit_end     (bit_end),
        .seg         (seg)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Hard sync at cycle 0, then cycles 1..maxn in frame; falling edges at e1/e2
    task automatic run_frame(input logic [7:0] tm, input logic [7:0] dv,
                             input int e1, input int e2, input int maxn,
                             output int seg1, output int t_n, output int s_n,
                             output int b_n, output int b2_n);
        timing   = tm;
        div_sel  = dv;
        in_frame = 1'b0;
        rx       = 1'b1;
        repeat (3) @(negedge clk);
        @(negedge clk);
        rx = 1'b0;
        seg1 = -1; t_n = -1; s_n = -1; b_n = -1; b2_n = -1;
        for (int n = 1; n <= maxn; n++) begin
            @(negedge clk);
            in_frame = 1'b1;
            rx = (n == e1 || n == e2) ? 1'b0 : 1'b1;
            #1;
            if (n == 1) seg1 = int'(seg);
            if (tq_tick && t_n < 0) t_n = n;
            if (sample_pulse && s_n < 0) s_n = n;
            if (bit_end) begin
                if (b_n < 0) b_n = n;
                else if (b2_n < 0) b2_n = n;
            end
        end
        in_frame = 1'b0;
        rx       = 1'b1;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 seg in reset", int'(seg), 0);
        chk("R1 strobes in reset", int'(sample_pulse) + int'(bit_end), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 seg after release", int'(seg), 0);
        chk("R1 strobes after release", int'(sample_pulse) + int'(bit_end), 0);
    endtask

    task automatic t_nominal();
        int s1, t, s, b, b2;
        run_frame(8'h84, 8'd0, 0, 0, 22, s1, t, s, b, b2);
        chk("R6 seg after hard sync", s1, 0);
        chk("R2 tick with div 0", t, 1);
        chk("R5 sample at end of phase 1 (0x84)", s, 8);
        chk("R4 bit length 0x84", b, 10);
        chk("R3 second bit length 0x84", b2, 20);
    endtask

    task automatic t_rate_slow();
        int s1, t, s, b, b2;
        run_frame(8'h5C, 8'd0, 0, 0, 25, s1, t, s, b, b2);
        chk("R4 sample 0x5C", s, 12);
        chk("R4 bit length 0x5C", b, 20);
    endtask

    task automatic t_prescale();
        int s1, t, s, b, b2;
        run_frame(8'h84, 8'd3, 0, 0, 45, s1, t, s, b, b2);
        chk("R2 first tick after restart div 3", t, 4);
        chk("R2 sample div 3", s, 32);
        chk("R2 bit length div 3", b, 40);
    endtask

    task automatic t_lengthen();
        int s1, t, s, b, b2;
        run_frame(8'h84, 8'd0, 3, 0, 15, s1, t, s, b, b2);
        chk("R7 sample after edge in propagation", s, 10);
        chk("R7 bit end after edge in propagation", b, 12);
    endtask

    task automatic t_jump_small();
        int s1, t, s, b, b2;
        run_frame(8'h88, 8'd0, 7, 0, 18, s1, t, s, b, b2);
        chk("R9 jump width 3 sample", s, 12);
        chk("R9 jump width 3 bit end", b, 15);
    endtask

    task automatic t_jump_cap();
        int s1, t, s, b, b2;
        run_frame(8'h9C, 8'd0, 9, 0, 30, s1, t, s, b, b2);
        chk("R9 jump width capped at 4 sample", s, 18);
        chk("R9 jump width capped at 4 bit end", b, 26);
    endtask

    task automatic t_shorten();
        int s1, t, s, b, b2;
        run_frame(8'h9C, 8'd0, 17, 0, 25, s1, t, s, b, b2);
        chk("R8 sample unaffected", s, 14);
        chk("R8 phase 2 cut by 4", b, 18);
        run_frame(8'h9C, 8'd0, 21, 0, 25, s1, t, s, b, b2);
        chk("R8 phase 2 cut by 1", b, 21);
        run_frame(8'h84, 8'd0, 10, 0, 15, s1, t, s, b, b2);
        chk("R8 edge on last quantum no cut", b, 10);
    endtask

    task automatic t_one_resync();
        int s1, t, s, b, b2;
        run_frame(8'h84, 8'd0, 3, 5, 15, s1, t, s, b, b2);
        chk("R10 second edge ignored sample", s, 10);
        chk("R10 second edge ignored bit end", b, 12);
        run_frame(8'h84, 8'd0, 11, 0, 25, s1, t, s, b, b2);
        chk("R10 edge in sync first bit", b, 10);
        chk("R10 edge in sync ignored", b2, 20);
    endtask

    task automatic t_coincide();
        int s1, t, s, b, b2;
        run_frame(8'h84, 8'd0, 8, 0, 15, s1, t, s, b, b2);
        chk("R11 sample postponed past edge tick", s, 10);
        chk("R11 bit end after postponed sample", b, 12);
    endtask

    initial begin
        rst_n    = 1'b0;
        div_sel  = 8'd0;
        timing   = 8'h84;
        rx       = 1'b1;
        in_frame = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_nominal();
        t_rate_slow();
        t_prescale();
        t_lengthen();
        t_jump_small();
        t_jump_cap();
        t_shorten();
        t_one_resync();
        t_coincide();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++;
        n_errs++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule